// File: doc/BRIEF.md
# Complementary Dead-Time PWM Generator

This block drives the gates of a three-phase motor bridge. A single up/down counter sets the PWM period. Each of the three bridge legs has a duty value and a pair of gate outputs. The upper output is on while the counter sits below the leg's duty value. The lower output carries the complement. A programmable guard interval separates the moment one output switches off from the moment its partner switches on, so the two gates of a leg are never on together.

Software programs the period, the three duty values, the guard interval and the counting mode through a simple write port. These values sit in holding registers and become active together at the next start of a PWM cycle. A fault input turns every gate off at once. The shutdown stays latched until software clears it while the input is low. The block also emits a single-cycle strobe each time the counter passes through zero, which can trigger an external converter.

Top module: `mcpwm_top`

## Requirements
- R1: In edge mode (mode bit 0 = 0) the counter counts 0, 1, ... up to the period P and then returns to 0, so a cycle lasts P+1 clocks.
- R2: In center mode (mode bit 0 = 1) the counter counts up from 0 to P and then back down to 1, so a cycle lasts 2P clocks and zero is visited once per cycle.
- R3: A leg's raw state is on while the count is below its duty value, in both modes. The gate outputs follow the raw state one clock later.
- R4: The lower output of each leg carries the complement of the upper output, except during the guard interval.
- R5: When a leg's raw state changes, both of its outputs are low for exactly D clocks, where D is the 8-bit guard value. The newly selected output then turns on. With D = 0 the outputs swap on the clock after the change.
- R6: The upper and lower outputs of one leg are never high together.
- R7: A duty value of 0 keeps the upper output off and the lower one on. A duty value ≥ P keeps the upper output on and the lower one off. Neither case produces any guard interval.
- R8: Writes to the period, duty, guard and mode registers take effect only at the next cycle start. A cycle already in progress runs on the previous values.
- R9: While fault_in is high, all six gate outputs are low in that same clock.
- R10: A fault is latched. Pulsing fault_clr while fault_in is low releases the latch. The outputs come back at the next cycle start. A fault_clr pulse while fault_in is high has no effect.
- R11: sync_pulse is high for exactly one clock, in the clock in which the counter is 0, as long as P ≥ 1. All outputs are low during reset.
- R12: The write port decodes wr_addr as 0 = period (data bits 14:0), 1 = guard (bits 7:0), 2 = mode (bit 0), and 3, 4, 5 = duty of legs 0, 1, 2 (bits 14:0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Register write data |
| fault_in | input | 1 | Fault request, active high |
| fault_clr | input | 1 | Software release of the latched fault |
| pwm_hi | output | 3 | Upper gate output per leg |
| pwm_lo | output | 3 | Lower gate output per leg |
| sync_pulse | output | 1 | Converter trigger strobe at counter zero |

## Verification
The main function is exercised in several configurations:
- Three legs are set to a mid duty, a zero duty and a duty above the period. This separates ordinary comparison with guard gaps from the two saturated cases.
- The same legs are run with a zero guard value and with a nonzero one. This shows that the gap length comes from the register and not from fixed logic.
- Edge-mode and center-mode runs are compared. The center-mode run is checked against its symmetric on-window and its single zero visit per cycle.
- A duty write in the middle of a cycle separates buffered loading from immediate loading.
- Two fault sequences are run. In one the release is issued while the fault pin is still high. This separates the pin-gated release from an unconditional one.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

    localparam int unsigned ADR_PERIOD    = 0;
    localparam int unsigned ADR_GUARD     = 1;
    localparam int unsigned ADR_MODE      = 2;
    localparam int unsigned ADR_DUTY_BASE = 3;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

endpackage

// File: rtl/mcpwm_counter.sv
module mcpwm_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    input  logic             center,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    import mcpwm_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        dir_e             dir;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (center) begin
            if (st_q.dir == DIR_UP) begin
                if (st_q.cnt >= period) begin
                    st_d.cnt = (st_q.cnt == '0) ? '0 : st_q.cnt - 1'b1;
                    st_d.dir = DIR_DOWN;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else begin
            st_d.cnt = (st_q.cnt >= period) ? '0 : st_q.cnt + 1'b1;
            st_d.dir = DIR_UP;
        end
        if (st_d.cnt == '0) begin
            st_d.dir = DIR_UP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, dir: DIR_UP};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign wrap = (st_d.cnt == '0);

endmodule

// File: rtl/mcpwm_pair.sv
module mcpwm_pair #(
    parameter int CNT_W = 15,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    input  logic [DT_W-1:0]  guard,
    output logic             hi,
    output logic             lo
);
    typedef struct packed {
        logic            raw;
        logic [DT_W-1:0] gap;
        logic            hi;
        logic            lo;
    } pair_st_t;

    pair_st_t st_d, st_q;
    logic     raw_now;

    always_comb begin
        raw_now = (duty != '0) && ((duty >= period) || (cnt < duty));
        st_d     = st_q;
        st_d.raw = raw_now;
        if (raw_now != st_q.raw) begin
            st_d.gap = guard;
            st_d.hi  = (guard == '0) ? raw_now  : 1'b0;
            st_d.lo  = (guard == '0) ? !raw_now : 1'b0;
        end else if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - 1'b1;
            st_d.hi  = (st_q.gap == DT_W'(1)) ? raw_now  : 1'b0;
            st_d.lo  = (st_q.gap == DT_W'(1)) ? !raw_now : 1'b0;
        end else begin
            st_d.hi  = raw_now;
            st_d.lo  = !raw_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi = st_q.hi;
    assign lo = st_q.lo;

endmodule

// File: rtl/mcpwm_fault.sv
module mcpwm_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    input  logic fault_clr,
    input  logic wrap,
    output logic gate_ok
);
    typedef struct packed {
        logic held;
        logic run;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fault_in) begin
            st_d.held = 1'b1;
        end else if (fault_clr) begin
            st_d.held = 1'b0;
        end
        if (fault_in || st_q.held) begin
            st_d.run = 1'b0;
        end else if (wrap) begin
            st_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{held: 1'b0, run: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_ok = st_q.run && !fault_in;

endmodule

// File: rtl/mcpwm_top.sv
module mcpwm_top #(
    parameter int NPAIR  = 3,
    parameter int CNT_W  = 15,
    parameter int DT_W   = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = $clog2(mcpwm_pkg::ADR_DUTY_BASE + NPAIR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fault_in,
    input  logic              fault_clr,
    output logic [NPAIR-1:0]  pwm_hi,
    output logic [NPAIR-1:0]  pwm_lo,
    output logic              sync_pulse
);
    import mcpwm_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0]            per;
        logic [NPAIR-1:0][CNT_W-1:0] duty;
        logic [DT_W-1:0]             guard;
        logic                        center;
    } cfg_t;

    typedef struct packed {
        cfg_t hold;
        cfg_t live;
        logic sync;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [CNT_W-1:0] cnt_w;
    logic             wrap_w;
    logic             gate_ok_w;
    logic [NPAIR-1:0] leg_hi, leg_lo;
    logic [CNT_W-1:0] per_live;
    logic             center_live;
    logic             unused_wdata;

    assign unused_wdata = ^wr_data;
    assign per_live     = st_q.live.per;
    assign center_live  = st_q.live.center;

    always_comb begin
        st_d      = st_q;
        st_d.sync = wrap_w;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_PERIOD)) begin
                st_d.hold.per = wr_data[CNT_W-1:0];
            end
            if (wr_addr == ADDR_W'(ADR_GUARD)) begin
                st_d.hold.guard = wr_data[DT_W-1:0];
            end
            if (wr_addr == ADDR_W'(ADR_MODE)) begin
                st_d.hold.center = wr_data[0];
            end
            for (int i = 0; i < NPAIR; i++) begin
                if (wr_addr == ADDR_W'(ADR_DUTY_BASE + i)) begin
                    st_d.hold.duty[i] = wr_data[CNT_W-1:0];
                end
            end
        end
        if (wrap_w) begin
            st_d.live = st_q.hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    mcpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (per_live),
        .center (center_live),
        .cnt    (cnt_w),
        .wrap   (wrap_w)
    );

    for (genvar g = 0; g < NPAIR; g++) begin : g_leg
        mcpwm_pair #(.CNT_W(CNT_W), .DT_W(DT_W)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt    (cnt_w),
            .period (per_live),
            .duty   (st_q.live.duty[g]),
            .guard  (st_q.live.guard),
            .hi     (leg_hi[g]),
            .lo     (leg_lo[g])
        );
    end

    mcpwm_fault u_flt (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_in  (fault_in),
        .fault_clr (fault_clr),
        .wrap      (wrap_w),
        .gate_ok   (gate_ok_w)
    );

    assign pwm_hi     = leg_hi & {NPAIR{gate_ok_w}};
    assign pwm_lo     = leg_lo & {NPAIR{gate_ok_w}};
    assign sync_pulse = st_q.sync;

endmodule

// File: rtl/mcpwm_checker.sv
module mcpwm_checker #(
    parameter int NPAIR = 3,
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fault_in,
    input logic [NPAIR-1:0] pwm_hi,
    input logic [NPAIR-1:0] pwm_lo,
    input logic             sync_pulse,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per,
    input logic             center
);

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_hi & pwm_lo) == '0);

    p_fault_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |-> (pwm_hi == '0 && pwm_lo == '0));

    p_fault_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> (pwm_hi == '0 && pwm_lo == '0));

    p_sync_at_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> cnt == '0);

    p_sync_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && per != '0) |=> !sync_pulse);

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= per);

    p_edge_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!center && cnt == per) |=> cnt == '0);

    p_center_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (center && cnt == per && per != '0) |=> cnt == CNT_W'($past(per) - 1'b1));

endmodule

bind mcpwm_top mcpwm_checker #(.NPAIR(NPAIR), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_in   (fault_in),
    .pwm_hi     (pwm_hi),
    .pwm_lo     (pwm_lo),
    .sync_pulse (sync_pulse),
    .cnt        (cnt_w),
    .per        (per_live),
    .center     (center_live)
);

// File: tb/mcpwm_tb_top.sv
module mcpwm_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        fault_in = 1'b0;
    logic        fault_clr = 1'b0;
    logic [2:0]  pwm_hi, pwm_lo;
    logic        sync_pulse;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        int         at;
        logic [6:0] mask;
        logic [6:0] val;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mcpwm_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .fault_in   (fault_in),
        .fault_clr  (fault_clr),
        .pwm_hi     (pwm_hi),
        .pwm_lo     (pwm_lo),
        .sync_pulse (sync_pulse)
    );

    // Monitor: compare the observed {sync, lo, hi} with queued expectations
    always @(negedge clk) begin
        logic [6:0] obs;
        obs = {sync_pulse, pwm_lo, pwm_hi};
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            exp_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (it.at < cyc || ((obs ^ it.val) & it.mask) != 0) begin
                n_fail++;
                $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                         it.tag, it.at, obs & it.mask, it.val & it.mask, it.mask);
            end
        end
    end

    task automatic expect_at(int c, logic [6:0] m, logic [6:0] v, string tag);
        sb_q.push_back('{c, m, v, tag});
    endtask

    task automatic at_cycle(int c);
        while (cyc < c) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic reg_write(logic [2:0] a, logic [15:0] v);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = v;
        @(posedge clk);
        #2;
        wr_en   = 1'b0;
    endtask

    task automatic wait_sync(output int base);
        at_cycle(cyc + 1);
        while (!sync_pulse) at_cycle(cyc + 1);
        base = cyc;
    endtask

    // Edge mode, P=9, guard 2, duties {12, 0, 4}
    function automatic logic [6:0] edge_vec(int c);
        return {c == 0, 1'b0, 1'b1, (c == 0 || c >= 7), 1'b1, 1'b0, (c == 3 || c == 4)};
    endfunction

    // Center mode, P=5, guard 1, duties {12, 0, 3}
    function automatic logic [6:0] ctr_vec(int c);
        return {c == 0, 1'b0, 1'b1, (c >= 5 && c <= 8), 1'b1, 1'b0, (c <= 3)};
    endfunction

    initial begin
        int base;
        expect_at(3, 7'h7f, 7'h00, "R11 reset outputs low");
        at_cycle(5);
        rst_n = 1'b1;
        at_cycle(6);
        // R12: register map
        reg_write(3'd0, 16'd9);
        reg_write(3'd1, 16'd2);
        reg_write(3'd2, 16'd0);
        reg_write(3'd3, 16'd4);
        reg_write(3'd4, 16'd0);
        reg_write(3'd5, 16'd12);
        repeat (3) wait_sync(base);

        // R1 R3 R4 R5 R7 R11 R12: edge mode full-cycle waveform
        for (int k = 0; k <= 10; k++)
            expect_at(base + k, 7'h7f, edge_vec(k % 10), "R1/R3/R4/R5/R7/R11 edge waveform");
        at_cycle(base + 11);

        // R8: mid-cycle duty write is deferred to the next cycle
        wait_sync(base);
        expect_at(base + 3, 7'h01, 7'h01, "R8 old duty on");
        expect_at(base + 4, 7'h01, 7'h01, "R8 old duty on");
        expect_at(base + 5, 7'h01, 7'h00, "R8 old duty off");
        for (int k = 13; k <= 16; k++) expect_at(base + k, 7'h01, 7'h01, "R8 new duty on");
        expect_at(base + 17, 7'h01, 7'h00, "R8 new duty off");
        expect_at(base + 18, 7'h08, 7'h00, "R8 new duty guard gap");
        expect_at(base + 19, 7'h08, 7'h08, "R8 new duty lower on");
        at_cycle(base + 2);
        reg_write(3'd3, 16'd6);
        at_cycle(base + 20);
        reg_write(3'd3, 16'd4);
        repeat (2) wait_sync(base);

        // R9 R10: fault, release with pin low, resume at cycle start
        wait_sync(base);
        for (int k = 3; k <= 9; k++) expect_at(base + k, 7'h3f, 7'h00, "R9/R10 fault outputs low");
        expect_at(base + 10, 7'h7f, edge_vec(0), "R10 resume at cycle start");
        expect_at(base + 11, 7'h7f, edge_vec(1), "R10 resume at cycle start");
        at_cycle(base + 3);  fault_in = 1'b1;
        at_cycle(base + 4);  fault_in = 1'b0;
        at_cycle(base + 6);  fault_clr = 1'b1;
        at_cycle(base + 7);  fault_clr = 1'b0;
        at_cycle(base + 12);

        // R10: release while the pin is high is ignored
        wait_sync(base);
        for (int k = 2; k <= 19; k++) expect_at(base + k, 7'h3f, 7'h00, "R10 clear ignored while pin high");
        expect_at(base + 20, 7'h7f, edge_vec(0), "R10 resume after valid clear");
        at_cycle(base + 2);  fault_in = 1'b1;
        at_cycle(base + 3);  fault_clr = 1'b1;
        at_cycle(base + 4);  fault_clr = 1'b0; fault_in = 1'b0;
        at_cycle(base + 12); fault_clr = 1'b1;
        at_cycle(base + 13); fault_clr = 1'b0;
        at_cycle(base + 21);

        // R5: zero guard gives a direct swap
        reg_write(3'd1, 16'd0);
        repeat (2) wait_sync(base);
        wait_sync(base);
        for (int k = 0; k <= 9; k++)
            expect_at(base + k, 7'h09,
                      {3'b000, (k == 0 || k >= 5), 2'b00, (k >= 1 && k <= 4)},
                      "R5 zero guard swap");
        at_cycle(base + 10);

        // R2 R3 R4 R5 R11: center mode
        reg_write(3'd0, 16'd5);
        reg_write(3'd3, 16'd3);
        reg_write(3'd1, 16'd1);
        reg_write(3'd2, 16'd1);
        repeat (3) wait_sync(base);
        wait_sync(base);
        for (int k = 0; k <= 10; k++)
            expect_at(base + k, 7'h7f, ctr_vec(k % 10), "R2/R3/R4/R5/R11 center waveform");
        at_cycle(base + 12);

        if (sb_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule